// File: doc/BRIEF.md
# ULPI Link-Side Register Access Engine

This block sits on the link side of an 8-bit ULPI bus and turns simple local requests into PHY register reads and writes. A requester presents a read or a write, an 8-bit register address and, for writes, a data byte. The engine builds the command byte, follows the DIR, NXT and STP handshake with the PHY, and answers with a one-cycle done pulse, which carries the read byte for reads. If the PHY takes the bus back before it has acknowledged the command, the engine answers with an aborted pulse so the requester can try again.

The engine owns the data bus only while DIR is low. It leaves one idle cycle whenever DIR changes, so the two sides never drive the bus at the same time. Addresses that a 6-bit command field cannot reach are sent as an extended command followed by a separate address byte. After reset it drives nothing until the PHY has let go of the bus, and its first command sets the PHY's soft-reset bit.

Top module: `ulpi_reg_engine`

## Requirements
- R1: After reset, data_oe and req_ready stay low until DIR has been sampled low on DIR_LOW_CYCLES (3) consecutive rising edges. The engine then writes BOOT_DATA (20h) to BOOT_ADDR (04h) with command byte 84h, and no done pulse follows that write.
- R2: In idle, while the engine owns the bus, data_oe is 1, data_out is 00h and stp is 0.
- R3: data_oe is 0 in every cycle in which DIR is high and in the first cycle after DIR falls. A request presented in those cycles is not accepted (req_ready is 0).
- R4: A write to an address below 40h, other than 2Fh, drives command byte {2'b10, addr[5:0]} until NXT is sampled high, then the data byte until NXT is sampled high, then one cycle of stp=1 with data_out 00h. rsp_done is 1 in the cycle after stp.
- R5: A read drives command byte {2'b11, field} until NXT is sampled high (after the extended address byte, if any). It releases the bus for the turnaround cycle and captures data_in on the following cycle. It pulses rsp_done with that byte in rsp_rdata in the cycle after the one in which DIR is seen low again.
- R6: An address of 40h or above, or exactly 2Fh, uses the extended form: the command's low six bits are 2Fh, and the full address byte follows it and is held until NXT is sampled high.
- R7: If DIR is high while the command or extended address byte still waits for NXT, the access is dropped. rsp_aborted is 1 in the next cycle and rsp_done is not pulsed. The bus stays released until DIR has been low for one cycle, and then the engine returns to idle.
- R8: rsp_done and rsp_aborted are single-cycle pulses and never both 1.
- R9: stp is high for exactly one cycle and only right after a cycle in which NXT was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on this edge if req_valid |
| rsp_done | output | 1 | Access completed (one cycle) |
| rsp_aborted | output | 1 | Access dropped because the PHY took the bus |
| rsp_rdata | output | 8 | Read data, valid with rsp_done of a read |
| ulpi_dir | input | 1 | PHY owns the bus when high |
| ulpi_nxt | input | 1 | PHY throttle / acknowledge |
| ulpi_stp | output | 1 | Link end-of-transfer strobe |
| ulpi_data_in | input | 8 | Data bus as seen by the link |
| ulpi_data_out | output | 8 | Data the link drives |
| ulpi_data_oe | output | 1 | Link output enable for the data bus |

## Verification
The bench drives a scripted PHY and checks, on every clock, that the link releases the bus during and just after DIR high. Writes and reads are tried at immediate addresses, at the 3Fh/40h boundary and at 2Fh, which must take the extended path, so a wrong range decode shows up in the command byte. NXT is withheld for several cycles on the command to show that bytes are held. Aborts are raised both on the command and on the extended address byte, and a request is held while the PHY sends a status burst to show that nothing is accepted until the turnaround has passed.

// File: rtl/ulpi_reg_engine.sv
module ulpi_reg_engine #(
  parameter logic [7:0] BOOT_ADDR      = 8'h04,
  parameter logic [7:0] BOOT_DATA      = 8'h20,
  parameter int         DIR_LOW_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       req_ready,
  output logic       rsp_done,
  output logic       rsp_aborted,
  output logic [7:0] rsp_rdata,
  input  logic       ulpi_dir,
  input  logic       ulpi_nxt,
  output logic       ulpi_stp,
  input  logic [7:0] ulpi_data_in,
  output logic [7:0] ulpi_data_out,
  output logic       ulpi_data_oe
);
  localparam int CW = (DIR_LOW_CYCLES > 1) ? $clog2(DIR_LOW_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIR_LOW_CYCLES - 1);
  localparam logic [5:0] EXT_FIELD = 6'h2F;

  typedef enum logic [3:0] {
    ST_WAIT, ST_IDLE, ST_CMD, ST_EADDR, ST_WDATA,
    ST_STP, ST_RTURN, ST_RDATA, ST_RWAIT, ST_HOLD
  } state_t;

  state_t        state;
  logic          dir_q;
  logic [CW-1:0] low_cnt;
  logic          op_wr, op_boot;
  logic [7:0]    op_addr, op_wdata;

  wire bus_free = !ulpi_dir && !dir_q;
  wire use_ext  = (op_addr >= 8'h40) || (op_addr[5:0] == EXT_FIELD);
  wire [7:0] cmd_byte = {1'b1, ~op_wr, use_ext ? EXT_FIELD : op_addr[5:0]};
  wire drives = (state == ST_IDLE) || (state == ST_CMD) || (state == ST_EADDR) ||
                (state == ST_WDATA) || (state == ST_STP);

  assign req_ready    = (state == ST_IDLE) && bus_free;
  assign ulpi_data_oe = drives && bus_free;
  assign ulpi_stp     = (state == ST_STP);

  always_comb begin
    case (state)
      ST_CMD:   ulpi_data_out = cmd_byte;
      ST_EADDR: ulpi_data_out = op_addr;
      ST_WDATA: ulpi_data_out = op_wdata;
      default:  ulpi_data_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_WAIT;
      dir_q       <= 1'b1;
      low_cnt     <= '0;
      op_wr       <= 1'b0;
      op_boot     <= 1'b0;
      op_addr     <= 8'h00;
      op_wdata    <= 8'h00;
      rsp_done    <= 1'b0;
      rsp_aborted <= 1'b0;
      rsp_rdata   <= 8'h00;
    end else begin
      dir_q       <= ulpi_dir;
      rsp_done    <= 1'b0;
      rsp_aborted <= 1'b0;
      case (state)
        ST_WAIT: begin
          if (ulpi_dir) low_cnt <= '0;
          else if (low_cnt == CNT_LAST) begin
            low_cnt  <= '0;
            op_wr    <= 1'b1;
            op_boot  <= 1'b1;
            op_addr  <= BOOT_ADDR;
            op_wdata <= BOOT_DATA;
            state    <= ST_CMD;
          end else low_cnt <= low_cnt + 1'b1;
        end
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            op_wr    <= req_write;
            op_boot  <= 1'b0;
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            state    <= ST_CMD;
          end
        end
        ST_CMD, ST_EADDR: begin
          if (ulpi_dir) begin
            rsp_aborted <= !op_boot;
            state       <= ST_HOLD;
          end else if (ulpi_nxt) begin
            if (state == ST_CMD && use_ext) state <= ST_EADDR;
            else if (op_wr)                 state <= ST_WDATA;
            else                            state <= ST_RTURN;
          end
        end
        ST_WDATA: if (ulpi_nxt) state <= ST_STP;
        ST_STP: begin
          rsp_done <= !op_boot;
          state    <= ST_IDLE;
        end
        ST_RTURN: state <= ST_RDATA;
        ST_RDATA: begin
          rsp_rdata <= ulpi_data_in;
          state     <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (!ulpi_dir) begin
            rsp_done <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_HOLD: if (!ulpi_dir) state <= op_boot ? ST_WAIT : ST_IDLE;
        default: state <= ST_WAIT;
      endcase
    end
  end

  a_r8_done_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !rsp_aborted);

  a_r9_stp_single: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |=> !ulpi_stp);

  a_r9_stp_after_nxt: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |-> $past(ulpi_nxt));

  a_r7_abort_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_aborted |-> $past(ulpi_dir));

  a_r3_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ulpi_dir) |-> !ulpi_data_oe);

endmodule

// File: tb/ulpi_reg_engine_bench.sv
module ulpi_reg_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
  logic       req_ready, rsp_done, rsp_aborted, ulpi_stp, ulpi_data_oe;
  logic [7:0] rsp_rdata, ulpi_data_out;
  logic       ulpi_dir = 1'b1, ulpi_nxt = 1'b0;
  logic [7:0] ulpi_data_in = 8'h00;
  int         n_checks = 0, n_fail = 0;
  logic       dir_prev = 1'b1;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  ulpi_reg_engine u_ulpi_reg_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_aborted(rsp_aborted), .rsp_rdata(rsp_rdata),
    .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_stp(ulpi_stp),
    .ulpi_data_in(ulpi_data_in), .ulpi_data_out(ulpi_data_out),
    .ulpi_data_oe(ulpi_data_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edge_();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  // Every-clock reference: bus released while PHY owns it and one cycle after; pulses exclusive
  always @(posedge clk) dir_prev <= ulpi_dir;
  always @(negedge clk) if (rst_n && !finished) begin
    if (ulpi_dir || dir_prev) chk("R3 oe while dir/turnaround", ulpi_data_oe, 1'b0);
    chk("R8 done&aborted", rsp_done & rsp_aborted, 1'b0);
  end

  task automatic idle_check(input string tag);
    chk({tag, " R2 oe"}, ulpi_data_oe, 1'b1);
    chk({tag, " R2 data"}, ulpi_data_out, 8'h00);
    chk({tag, " R2 stp"}, ulpi_stp, 1'b0);
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d, input int stall);
    bit ext;
    logic [7:0] cmd;
    ext = (a >= 8'h40) || (a == 8'h2F);
    cmd = {1'b1, !wr, ext ? 6'h2F : a[5:0]};
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    settle();
    while (!req_ready) begin edge_(); settle(); end
    edge_();
    req_valid = 1'b0;
    for (int i = 0; i < stall; i++) begin
      settle();
      chk("R4 cmd held", ulpi_data_out, cmd);
      chk("R4 oe in cmd", ulpi_data_oe, 1'b1);
      edge_();
    end
    ulpi_nxt = 1'b1; settle();
    chk(wr ? "R4 cmd byte" : "R5 cmd byte", ulpi_data_out, cmd);
    edge_();
    if (ext) begin
      ulpi_nxt = 1'b0; settle();
      chk("R6 ext addr held", ulpi_data_out, a);
      edge_();
      ulpi_nxt = 1'b1; settle();
      chk("R6 ext addr byte", ulpi_data_out, a);
      edge_();
    end
    if (wr) begin
      ulpi_nxt = 1'b1; settle();
      chk("R4 data byte", ulpi_data_out, d);
      chk("R9 no stp yet", ulpi_stp, 1'b0);
      edge_();
      ulpi_nxt = 1'b0; settle();
      chk("R4 stp", ulpi_stp, 1'b1);
      chk("R4 stp data", ulpi_data_out, 8'h00);
      edge_(); settle();
      chk("R4 done", rsp_done, 1'b1);
      chk("R9 stp single", ulpi_stp, 1'b0);
    end else begin
      ulpi_nxt = 1'b0; ulpi_dir = 1'b1; settle();
      chk("R5 turnaround oe", ulpi_data_oe, 1'b0);
      edge_();
      ulpi_data_in = d; settle();
      chk("R5 data phase oe", ulpi_data_oe, 1'b0);
      edge_();
      ulpi_dir = 1'b0; ulpi_data_in = 8'h00; settle();
      chk("R5 no early done", rsp_done, 1'b0);
      edge_(); settle();
      chk("R5 done", rsp_done, 1'b1);
      chk("R5 rdata", rsp_rdata, d);
    end
    chk("R8 no abort", rsp_aborted, 1'b0);
    idle_check("after access");
    edge_(); settle();
    chk("R8 done single", rsp_done, 1'b0);
  endtask

  task automatic abort_access(input bit wr, input logic [7:0] a, input bit at_ext);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = 8'h11;
    settle();
    while (!req_ready) begin edge_(); settle(); end
    edge_();
    req_valid = 1'b0;
    if (at_ext) begin ulpi_nxt = 1'b1; edge_(); ulpi_nxt = 1'b0; end
    ulpi_dir = 1'b1; settle();
    chk("R7 bus released", ulpi_data_oe, 1'b0);
    edge_(); settle();
    chk("R7 aborted", rsp_aborted, 1'b1);
    chk("R7 no done", rsp_done, 1'b0);
    chk("R7 not ready", req_ready, 1'b0);
    edge_(); settle();
    chk("R8 abort single", rsp_aborted, 1'b0);
    ulpi_dir = 1'b0; settle();
    chk("R7 turnaround oe", ulpi_data_oe, 1'b0);
    chk("R7 turnaround ready", req_ready, 1'b0);
    edge_(); settle();
    chk("R7 back ready", req_ready, 1'b1);
    idle_check("R7 after abort");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R1 reset oe", ulpi_data_oe, 1'b0);
    chk("R1 reset ready", req_ready, 1'b0);
    chk("R9 reset stp", ulpi_stp, 1'b0);
    rst_n = 1'b1;
    // PHY holds DIR during its start-up
    for (int i = 0; i < 4; i++) begin
      edge_(); settle();
      chk("R1 no drive while dir", ulpi_data_oe, 1'b0);
    end
    edge_();
    ulpi_dir = 1'b0;
    for (int i = 0; i < 3; i++) begin
      settle();
      chk("R1 waiting oe", ulpi_data_oe, 1'b0);
      chk("R1 waiting ready", req_ready, 1'b0);
      edge_();
    end
    settle();
    chk("R1 boot cmd", ulpi_data_out, 8'h84);
    chk("R1 boot oe", ulpi_data_oe, 1'b1);
    edge_(); ulpi_nxt = 1'b1; settle();
    chk("R1 boot cmd held", ulpi_data_out, 8'h84);
    edge_(); settle();
    chk("R1 boot data", ulpi_data_out, 8'h20);
    edge_(); ulpi_nxt = 1'b0; settle();
    chk("R1 boot stp", ulpi_stp, 1'b1);
    edge_(); settle();
    chk("R1 no done for boot", rsp_done, 1'b0);
    chk("R1 ready after boot", req_ready, 1'b1);
    idle_check("R1 idle");

    access(1'b1, 8'h0A, 8'h5C, 2);   // R4 immediate write with stall
    access(1'b0, 8'h16, 8'hA7, 1);   // R5 immediate read
    access(1'b0, 8'h3F, 8'h3C, 0);   // R5 top immediate address
    access(1'b1, 8'h40, 8'h99, 0);   // R6 first extended address
    access(1'b1, 8'h85, 8'h3E, 1);   // R6 extended write
    access(1'b0, 8'h2F, 8'hD2, 0);   // R6 2Fh goes extended

    abort_access(1'b1, 8'h07, 1'b0); // R7 abort on command
    access(1'b1, 8'h07, 8'h11, 0);   // retry succeeds
    abort_access(1'b0, 8'hC3, 1'b1); // R7 abort on extended address
    access(1'b0, 8'hC3, 8'h6B, 0);

    // R3: PHY status burst while a request waits
    edge_();
    ulpi_dir = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h19; req_wdata = 8'h42;
    settle();
    chk("R3 ready during dir", req_ready, 1'b0);
    edge_(); settle();
    chk("R3 ready during dir 2", req_ready, 1'b0);
    edge_(); ulpi_dir = 1'b0; settle();
    chk("R3 ready on fall", req_ready, 1'b0);
    chk("R3 oe on fall", ulpi_data_oe, 1'b0);
    edge_(); settle();
    chk("R3 ready after turnaround", req_ready, 1'b1);
    access(1'b1, 8'h19, 8'h42, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule